// File: doc/BRIEF.md
# Dual Byte Stack Unit

This block keeps the two LIFO stores of a small stack-machine core, each one byte wide: a data stack (index 0) and a return stack (index 1). The core's decoder gives it the mode flags of each instruction and the number of operands to remove and results to add. The block returns the top two operands from the source stack. In short mode each operand is built from two bytes. It takes the results that the core's datapath computes from those operands and writes them back in the same clock cycle.

The return flag selects the return stack as the source of operands and the destination of results. The keep flag lets an instruction read its operands without removing them. The stash request moves one operand to the opposite stack. Depth underflow and overflow are recorded in sticky flags, which only a synchronous reset clears. Every operation, including the largest (two 16-bit pops and two 16-bit pushes), finishes in one clock cycle.

Top module: `dual_byte_stack`

## Requirements
- R1: When `rst` is high at a clock edge, both levels become 0 and `underflow` and `overflow` become 0. Reads from an empty stack give zero.
- R2: When `wide`=0, `opnd0` is the top byte of the source stack and `opnd1` is the byte below it. Bits 15:8 of both are zero.
- R3: When `wide`=1, `opnd0` = {second byte, top byte} and `opnd1` = {fourth byte, third byte}, counting down from the top.
- R4: An operation without keep removes `pop_cnt` operands (bytes or byte pairs) and then pushes `push_cnt` results, `res0` first and `res1` last, so that `res1` ends on top. In byte mode only bits 7:0 are pushed. In short mode the high byte is pushed before the low byte.
- R5: With `keep`=1 the source level is not lowered. Results are pushed above the operands that were read.
- R6: With `ret_sel`=1 operands are read from the return stack and results are pushed onto it, and the data stack is left unchanged. With `ret_sel`=0 the roles are reversed.
- R7: A `stash` operation ignores `pop_cnt`/`push_cnt`. It pops one operand from the source stack and pushes that operand, in the same byte layout, onto the other stack. It goes data to return when `ret_sel`=0 and return to data when `ret_sel`=1.
- R8: If an operation needs more bytes than the source level holds, `underflow` is set and stays set. The missing bytes read as zero, and the source level becomes 0 unless `keep` is set.
- R9: If a push would go beyond DEPTH bytes, `overflow` is set and stays set. The extra bytes are dropped and the level saturates at DEPTH.
- R10: While `op_valid` is low, neither level changes and no byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Apply the operation at this clock edge |
| ret_sel | input | 1 | Return flag: the return stack is the source |
| keep | input | 1 | Read operands without removing them |
| wide | input | 1 | Short mode: operands and results are 16 bits |
| stash | input | 1 | Move one operand to the other stack |
| pop_cnt | input | 2 | Number of operands consumed (0 to 2) |
| push_cnt | input | 2 | Number of results pushed (0 to 2) |
| res0 | input | 16 | First result pushed |
| res1 | input | 16 | Second result pushed (ends on top) |
| opnd0 | output | 16 | Top operand of the source stack |
| opnd1 | output | 16 | Second operand of the source stack |
| dat_level | output | 9 | Data stack byte count (0 to DEPTH) |
| ret_level | output | 9 | Return stack byte count (0 to DEPTH) |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |

## Verification
The checker watches the level bookkeeping on every cycle: levels frozen while idle, the data level untouched by return-stack work and by a keep with no results, a stash moving exactly one byte between stacks, levels capped at DEPTH, the sticky flags, and the reset state. Byte contents can only be seen through the bench's scenarios. These cover operand packing in both widths, push order of the two results, the value carried by a stash in each direction, zero fill on underflow, and the top value surviving a dropped overflow byte.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  // number of bytes moved for n operands
  function automatic logic [2:0] byte_count(input logic [1:0] n, input logic wide);
    return wide ? {n, 1'b0} : {1'b0, n};
  endfunction

  // operand from two bytes counted from the top: lo is nearer the top
  function automatic logic [15:0] join_operand(input logic [7:0] lo, input logic [7:0] hi,
                                               input logic wide);
    return wide ? {hi, lo} : {8'h00, lo};
  endfunction

  // byte k sits at [8k+7:8k]; byte 0 is written first (deepest)
  function automatic logic [31:0] push_order(input logic wide, input logic [15:0] a,
                                             input logic [15:0] b);
    return wide ? {b[7:0], b[15:8], a[7:0], a[15:8]} : {16'h0000, b[7:0], a[7:0]};
  endfunction

endpackage

// File: rtl/dbs_bank.sv
module dbs_bank #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic [CW-1:0] level,
  input  logic          wr_go,
  input  logic [CW-1:0] wr_base,
  input  logic [2:0]    wr_num,
  input  logic [31:0]   wr_bytes,
  output logic [31:0]   top_bytes
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      logic [CW:0] wa;
      wa = {1'b0, wr_base} + (CW+1)'(k);
      if (wr_go && (3'(k) < wr_num) && (wa < (CW+1)'(DEPTH)))
        mem[wa[AW-1:0]] <= wr_bytes[8*k +: 8];
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_rd
    logic [CW-1:0] ra;
    assign ra = level - CW'(k + 1);
    assign top_bytes[8*k +: 8] = (level > CW'(k)) ? mem[ra[AW-1:0]] : 8'h00;
  end

endmodule

// File: rtl/dbs_plan.sv
module dbs_plan
  import dbs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] lvl_d,
  input  logic [CW-1:0] lvl_r,
  input  logic          op_valid,
  input  logic          ret_sel,
  input  logic          keep,
  input  logic          wide,
  input  logic          stash,
  input  logic [1:0]    pop_cnt,
  input  logic [1:0]    push_cnt,
  output logic [CW-1:0] nxt_d,
  output logic [CW-1:0] nxt_r,
  output logic          wr_go_d,
  output logic          wr_go_r,
  output logic [CW-1:0] wr_base,
  output logic [2:0]    wr_num,
  output logic          uflow_ev,
  output logic          oflow_ev
);
  logic          dst_r, short_src;
  logic [1:0]    pops, pushes;
  logic [2:0]    npop, npush;
  logic [CW-1:0] src_lvl, src_left, push_lvl;
  logic [CW:0]   top_end;

  always_comb begin
    pops      = stash ? 2'd1 : pop_cnt;
    pushes    = stash ? 2'd1 : push_cnt;
    npop      = byte_count(pops, wide);
    npush     = byte_count(pushes, wide);
    dst_r     = stash ? ~ret_sel : ret_sel;
    src_lvl   = ret_sel ? lvl_r : lvl_d;
    short_src = CW'(npop) > src_lvl;
    if (keep)           src_left = src_lvl;
    else if (short_src) src_left = '0;
    else                src_left = src_lvl - CW'(npop);
    wr_base  = (dst_r == ret_sel) ? src_left : (dst_r ? lvl_r : lvl_d);
    wr_num   = npush;
    top_end  = {1'b0, wr_base} + (CW+1)'(npush);
    uflow_ev = op_valid && short_src;
    oflow_ev = op_valid && (top_end > (CW+1)'(DEPTH));
    push_lvl = (top_end > (CW+1)'(DEPTH)) ? CW'(DEPTH) : top_end[CW-1:0];
    nxt_d = lvl_d;
    nxt_r = lvl_r;
    if (op_valid) begin
      if (ret_sel) nxt_r = src_left; else nxt_d = src_left;
      if (dst_r)   nxt_r = push_lvl; else nxt_d = push_lvl;
    end
    wr_go_d = op_valid && !dst_r;
    wr_go_r = op_valid && dst_r;
  end

endmodule

// File: rtl/dual_byte_stack.sv
module dual_byte_stack
  import dbs_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          ret_sel,
  input  logic          keep,
  input  logic          wide,
  input  logic          stash,
  input  logic [1:0]    pop_cnt,
  input  logic [1:0]    push_cnt,
  input  logic [15:0]   res0,
  input  logic [15:0]   res1,
  output logic [15:0]   opnd0,
  output logic [15:0]   opnd1,
  output logic [CW-1:0] dat_level,
  output logic [CW-1:0] ret_level,
  output logic          underflow,
  output logic          overflow
);
  localparam int NSTK = 2;

  logic [CW-1:0] lvl   [NSTK];
  logic [CW-1:0] nxt   [NSTK];
  logic [31:0]   top_b [NSTK];
  logic          wr_go [NSTK];
  logic [CW-1:0] wr_base;
  logic [2:0]    wr_num;
  logic [31:0]   wr_bytes, src_b;
  logic          uflow_ev, oflow_ev;

  dbs_plan #(.DEPTH(DEPTH), .CW(CW)) u_plan (
    .lvl_d(lvl[0]), .lvl_r(lvl[1]), .op_valid(op_valid), .ret_sel(ret_sel),
    .keep(keep), .wide(wide), .stash(stash), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
    .nxt_d(nxt[0]), .nxt_r(nxt[1]), .wr_go_d(wr_go[0]), .wr_go_r(wr_go[1]),
    .wr_base(wr_base), .wr_num(wr_num), .uflow_ev(uflow_ev), .oflow_ev(oflow_ev)
  );

  for (genvar s = 0; s < NSTK; s++) begin : g_stk
    dbs_bank #(.DEPTH(DEPTH), .CW(CW)) u_bank (
      .clk(clk), .level(lvl[s]), .wr_go(wr_go[s]), .wr_base(wr_base),
      .wr_num(wr_num), .wr_bytes(wr_bytes), .top_bytes(top_b[s])
    );
    always_ff @(posedge clk) begin
      if (rst) lvl[s] <= '0;
      else     lvl[s] <= nxt[s];
    end
  end

  assign src_b    = ret_sel ? top_b[1] : top_b[0];
  assign opnd0    = wide ? join_operand(src_b[7:0], src_b[15:8], 1'b1)
                         : join_operand(src_b[7:0], 8'h00, 1'b0);
  assign opnd1    = wide ? join_operand(src_b[23:16], src_b[31:24], 1'b1)
                         : join_operand(src_b[15:8], 8'h00, 1'b0);
  assign wr_bytes = stash ? push_order(wide, opnd0, 16'h0000)
                          : push_order(wide, res0, res1);

  always_ff @(posedge clk) begin
    if (rst) begin
      underflow <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      underflow <= underflow | uflow_ev;
      overflow  <= overflow | oflow_ev;
    end
  end

  assign dat_level = lvl[0];
  assign ret_level = lvl[1];

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          ret_sel,
  input logic          keep,
  input logic          wide,
  input logic          stash,
  input logic [1:0]    pop_cnt,
  input logic [1:0]    push_cnt,
  input logic [CW-1:0] dat_level,
  input logic [CW-1:0] ret_level,
  input logic          underflow,
  input logic          overflow,
  input logic          uflow_ev,
  input logic          oflow_ev
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dat_level == '0 && ret_level == '0 && !underflow && !overflow));

  a_r5_keep_holds: assert property (@(posedge clk) disable iff (rst)
    (op_valid && keep && !ret_sel && !stash && push_cnt == 2'd0) |=> $stable(dat_level));

  a_r6_return_only: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ret_sel && !stash) |=> $stable(dat_level));

  a_r7_stash_moves: assert property (@(posedge clk) disable iff (rst)
    (op_valid && stash && !ret_sel && !keep && !wide && dat_level != '0
     && ret_level < CW'(DEPTH))
    |=> (dat_level == $past(dat_level) - CW'(1) && ret_level == $past(ret_level) + CW'(1)));

  a_r8_underflow_seen: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ret_sel && !stash && !wide && CW'(pop_cnt) > dat_level) |=> underflow);

  a_r8_event_flags: assert property (@(posedge clk) disable iff (rst)
    uflow_ev |=> underflow);

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r9_event_flags: assert property (@(posedge clk) disable iff (rst)
    oflow_ev |=> overflow);

  a_r9_level_cap: assert property (@(posedge clk) disable iff (rst)
    (dat_level <= CW'(DEPTH) && ret_level <= CW'(DEPTH)));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(dat_level) && $stable(ret_level)));

endmodule

bind dual_byte_stack dbs_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .ret_sel(ret_sel), .keep(keep),
  .wide(wide), .stash(stash), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
  .dat_level(dat_level), .ret_level(ret_level), .underflow(underflow),
  .overflow(overflow), .uflow_ev(uflow_ev), .oflow_ev(oflow_ev)
);

// File: tb/sim_dual_byte_stack.sv
module sim_dual_byte_stack;
  localparam int DEPTH = 256;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 0, ret_sel = 0, keep = 0, wide = 0, stash = 0;
  logic [1:0] pop_cnt = 0, push_cnt = 0;
  logic [15:0] res0 = 0, res1 = 0;
  logic [15:0] opnd0, opnd1;
  logic [CW-1:0] dat_level, ret_level;
  logic underflow, overflow;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_byte_stack #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .ret_sel(ret_sel), .keep(keep),
    .wide(wide), .stash(stash), .pop_cnt(pop_cnt), .push_cnt(push_cnt),
    .res0(res0), .res1(res1), .opnd0(opnd0), .opnd1(opnd1),
    .dat_level(dat_level), .ret_level(ret_level),
    .underflow(underflow), .overflow(overflow)
  );

  typedef struct packed {
    logic        ret, kp, wd, st;
    logic [1:0]  pop, push;
    logic [15:0] r0, r1, pre;
    logic [8:0]  dl, rl;
    logic [15:0] d16, r16;
  } vec_t;

  // pre: opnd0 under the vector's own flags before the operation
  // d16/r16: 16-bit top of data/return stack afterwards
  localparam vec_t VEC [6] = '{
    '{1'b0,1'b0,1'b1,1'b0,2'd0,2'd2,16'h1234,16'hABCD,16'h0000,9'd4,9'd0,16'hABCD,16'h0000},
    '{1'b0,1'b0,1'b0,1'b0,2'd2,2'd1,16'h0055,16'h0000,16'h00CD,9'd3,9'd0,16'h3455,16'h0000},
    '{1'b0,1'b0,1'b1,1'b1,2'd0,2'd0,16'h0000,16'h0000,16'h3455,9'd1,9'd2,16'h0012,16'h3455},
    '{1'b1,1'b1,1'b1,1'b0,2'd1,2'd1,16'hBEEF,16'h0000,16'h3455,9'd1,9'd4,16'h0012,16'hBEEF},
    '{1'b1,1'b0,1'b0,1'b1,2'd0,2'd0,16'h0000,16'h0000,16'h00EF,9'd2,9'd3,16'h12EF,16'h55BE},
    '{1'b1,1'b0,1'b0,1'b0,2'd1,2'd2,16'h0001,16'h0002,16'h00BE,9'd2,9'd4,16'h12EF,16'h0102}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; ret_sel = 0; keep = 0; wide = 1; stash = 0; pop_cnt = 0; push_cnt = 0;
  endtask

  task automatic apply(input logic r, input logic k, input logic w, input logic s,
                       input logic [1:0] pc, input logic [1:0] uc,
                       input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    op_valid = 1; ret_sel = r; keep = k; wide = w; stash = s;
    pop_cnt = pc; push_cnt = uc; res0 = a; res1 = b;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_inputs();
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    do_reset();
    #1;
    chk("R1 dat_level", dat_level, 0);
    chk("R1 ret_level", ret_level, 0);
    chk("R1 flags", {underflow, overflow}, 0);
    chk("R1 empty reads zero", opnd0, 0);

    for (int i = 0; i < 6; i++) begin
      string tag;
      vec_t v;
      v = VEC[i];
      tag = v.st ? "R7" : (v.kp ? "R5" : (v.ret ? "R6" : "R4"));
      apply(v.ret, v.kp, v.wd, v.st, v.pop, v.push, v.r0, v.r1);
      #1 chk(v.wd ? "R3 operand" : "R2 operand", opnd0, v.pre);
      @(negedge clk); idle_inputs();
      #1;
      chk({tag, " dat_level"}, dat_level, v.dl);
      chk({tag, " ret_level"}, ret_level, v.rl);
      chk({tag, " data top"}, opnd0, v.d16);
      ret_sel = 1;
      #1 chk({tag, " return top"}, opnd0, v.r16);
      chk({tag, " no flags"}, {underflow, overflow}, 0);
    end

    // R10: idle cycles with busy-looking inputs change nothing
    @(negedge clk); idle_inputs(); push_cnt = 2; pop_cnt = 2; stash = 1; res0 = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 dat_level", dat_level, 2);
    chk("R10 ret_level", ret_level, 4);
    idle_inputs(); ret_sel = 1;
    #1 chk("R10 return top", opnd0, 16'h0102);

    // R8: pop two shorts with only two data bytes
    apply(1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 16'h0, 16'h0);
    #1;
    chk("R8 partial operand", opnd0, 16'h12EF);
    chk("R8 missing reads zero", opnd1, 16'h0000);
    @(negedge clk); idle_inputs();
    #1;
    chk("R8 underflow set", underflow, 1);
    chk("R8 level emptied", dat_level, 0);
    chk("R8 return untouched", ret_level, 4);
    repeat (2) @(negedge clk);
    #1 chk("R8 sticky", underflow, 1);
    chk("R9 no overflow", overflow, 0);

    do_reset();
    #1 chk("R1 clears underflow", underflow, 0);

    // R9: fill the data stack then push one byte more
    for (int j = 0; j < DEPTH / 4; j++)
      apply(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd2, 16'h1111, 16'h00C3);
    @(negedge clk); idle_inputs();
    #1;
    chk("R9 full level", dat_level, DEPTH);
    chk("R9 no overflow at full", overflow, 0);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 16'h0077, 16'h0);
    @(negedge clk); idle_inputs();
    #1;
    chk("R9 overflow set", overflow, 1);
    chk("R9 level saturates", dat_level, DEPTH);
    chk("R9 dropped byte", opnd0, 16'h00C3);
    @(negedge clk);
    #1 chk("R9 sticky", overflow, 1);

    do_reset();
    #1;
    chk("R1 clears overflow", overflow, 0);
    chk("R1 level after reset", dat_level, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule